// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of virtual-to-physical page translations for 4 KB pages. Each slot keeps a virtual page number, a physical frame number, a valid flag, a global flag and a 12-bit address-space tag. A lookup presents a virtual address together with the current address-space tag. In the same cycle it returns hit or miss and the physical address, which is the stored frame number joined to the untouched 12-bit page offset.

Because slots are tagged, one virtual page may be cached for several address spaces at once. A context switch therefore needs no flush. Global slots, typically kernel mappings, answer every address space. After a miss, the page walker outside the block installs the translation through the fill port. A second-chance clock chooses the slot to replace. A one-cycle invalidate command removes every slot, every non-global slot, or only the non-global slots of one address space.

The victim choice has three named outcomes, held in `pick_e`. PICK_FREE: a slot is empty, and the lowest-numbered empty slot is taken. PICK_SWEEP: starting at the hand, the clock clears the reference bit of each referenced slot it passes and takes the first unreferenced one. PICK_WRAP: every slot was referenced, so all bits are cleared and the slot under the hand is taken. After a sweep or a wrap the hand moves to the slot after the victim. After a free pick, or after a fill that overwrites a slot in place, the hand stays where it is.

Top module: `asid_tlb`

## Requirements
- R1: The low 12 bits of `lk_pa` equal the low 12 bits of `lk_va` on a hit. The upper bits equal the stored frame number. Both are available combinationally in the cycle of the lookup.
- R2: A non-global slot hits only when its page number equals `lk_va[VA_W-1:12]` and its stored tag equals `cur_asid`. The tag stored by a fill is `cur_asid` during the fill cycle.
- R3: A global slot (`fill_global`=1 at fill) hits on its page number alone, whatever `cur_asid` is.
- R4: Non-global slots with the same page number but different tags coexist, and each returns its own frame.
- R5: When a slot is empty, a fill takes the lowest-numbered empty slot and leaves the hand unchanged.
- R6: The clock policy works as follows. A fill sets the written slot's reference bit, and a lookup hit sets the hit slot's bit. When no slot is empty, the sweep starts at the hand, clears each set bit it passes and evicts the first slot whose bit is clear. If every bit is set, the sweep evicts the slot under the hand. The hand then points to the slot after the victim.
- R7: A fill whose page number and tag match a valid non-global slot, or whose page number matches a valid global slot when `fill_global`=1, rewrites that slot in place. It sets that slot's reference bit and does not move the hand.
- R8: With `inv_en`=1, `inv_op`=0 removes every slot, and `inv_op`=3 changes nothing.
- R9: With `inv_en`=1 and `inv_op`=1, every non-global slot is removed and global slots stay valid.
- R10: With `inv_en`=1 and `inv_op`=2, only the non-global slots whose tag equals `inv_asid` are removed. Global slots survive, even when their stored tag equals `inv_asid`.
- R11: A lookup in the same cycle as an invalidate sees the contents from before the invalidate. The removal shows from the next cycle.
- R12: After reset, every slot is empty, every lookup misses, and the hand points to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Virtual address to translate |
| cur_asid | input | 12 | Current address-space tag, used by lookup and fill |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Translated physical address, zero on a miss |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_va | input | VA_W | Virtual address of the translation to install |
| fill_pa | input | PA_W | Physical address of the frame to install |
| fill_global | input | 1 | Install as a global translation |
| inv_en | input | 1 | Perform an invalidate at the next edge |
| inv_op | input | 2 | 0 all, 1 non-global, 2 one tag, 3 nothing |
| inv_asid | input | 12 | Tag whose slots are removed when `inv_op`=2 |

## Verification
The bench builds the block with its defaults: four slots and 32-bit virtual and physical addresses. With four slots, four fills fill the array. A handful of further fills then takes the clock through every pick outcome: a full wrap, a sweep that stops at once, a sweep that clears one bit, and a sweep that clears two bits. Each of these is observed through which older translation stops hitting. The small size also places an in-place rewrite right before a sweep, where a wrongly allocated duplicate would evict a different slot and change which lookups miss afterwards.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PAGE_BITS = 12;
    localparam int ASID_W    = 12;

    typedef enum logic [1:0] {
        INV_ALL      = 2'd0,
        INV_NONGLOB  = 2'd1,
        INV_ONE_ASID = 2'd2,
        INV_NONE     = 2'd3
    } inv_op_e;

    typedef enum logic [1:0] {
        PICK_FREE  = 2'd0,
        PICK_SWEEP = 2'd1,
        PICK_WRAP  = 2'd2
    } pick_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N      = 4,
    parameter int VPN_W  = 20,
    parameter int TAG_W  = 12,
    parameter bit EXACT  = 1'b0,
    localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][VPN_W-1:0] ent_vpn,
    input  logic [N-1:0][TAG_W-1:0] ent_tag,
    input  logic [N-1:0]            ent_valid,
    input  logic [N-1:0]            ent_glob,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [TAG_W-1:0]        key_tag,
    input  logic                    key_glob,
    output logic [N-1:0]            match,
    output logic                    any,
    output logic [IW-1:0]           first
);

    // EXACT=0: lookup semantics (global ignores tag).
    // EXACT=1: fill-duplicate semantics (global flag must agree too).
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic vpn_eq, tag_eq, glob_ok, priv_ok;
        assign vpn_eq  = (ent_vpn[i] == key_vpn);
        assign tag_eq  = (ent_tag[i] == key_tag);
        assign glob_ok = ent_glob[i] & (key_glob | !EXACT);
        assign priv_ok = !ent_glob[i] & (!key_glob | !EXACT) & tag_eq;
        assign match[i] = ent_valid[i] & vpn_eq & (glob_ok | priv_ok);
    end

    always_comb begin
        any   = |match;
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) first = IW'(i);
        end
    end

endmodule

// File: rtl/tlb_clock_repl.sv
module tlb_clock_repl
    import tlb_pkg::*;
#(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  refb,
    input  logic [IW-1:0] hand,
    output pick_e         mode,
    output logic [IW-1:0] victim,
    output logic [N-1:0]  clr,
    output logic [IW-1:0] hand_nxt
);

    logic          has_free;
    logic [IW-1:0] free_idx;
    logic          found;
    logic [IW-1:0] sweep_idx;
    logic [N-1:0]  sweep_clr;

    // lowest-numbered empty slot
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    // second-chance sweep starting at the hand
    always_comb begin
        found     = 1'b0;
        sweep_idx = hand;
        sweep_clr = '0;
        for (int k = 0; k < N; k++) begin
            if (!found) begin
                if (refb[(int'(hand) + k) % N]) begin
                    sweep_clr[(int'(hand) + k) % N] = 1'b1;
                end else begin
                    found     = 1'b1;
                    sweep_idx = IW'((int'(hand) + k) % N);
                end
            end
        end
    end

    always_comb begin
        if (has_free)   mode = PICK_FREE;
        else if (found) mode = PICK_SWEEP;
        else            mode = PICK_WRAP;
    end

    always_comb begin
        unique case (mode)
            PICK_FREE: begin
                victim = free_idx;
                clr    = '0;
            end
            PICK_SWEEP: begin
                victim = sweep_idx;
                clr    = sweep_clr;
            end
            default: begin
                victim = hand;
                clr    = '1;
            end
        endcase
        hand_nxt = IW'((int'(victim) + 1) % N);
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int N    = 4,
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    input  logic              fill_en,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic              fill_global,
    input  logic              inv_en,
    input  logic [1:0]        inv_op,
    input  logic [ASID_W-1:0] inv_asid
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PFN_W = PA_W - PAGE_BITS;
    localparam int IW    = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0][VPN_W-1:0]  vpn_q;
    logic [N-1:0][PFN_W-1:0]  pfn_q;
    logic [N-1:0][ASID_W-1:0] tag_q;
    logic [N-1:0]             valid_q, glob_q, ref_q;
    logic [IW-1:0]            hand_q;

    logic [N-1:0]  lk_match, f_match;
    logic          lk_any, f_any;
    logic [IW-1:0] lk_idx, f_idx;

    pick_e         pick_mode;
    logic [IW-1:0] victim, hand_nxt, wr_idx;
    logic [N-1:0]  sweep_clr, kill;

    logic [N-1:0]  valid_n, ref_n;
    logic [IW-1:0] hand_n;
    inv_op_e       op;

    tlb_cam #(.N(N), .VPN_W(VPN_W), .TAG_W(ASID_W), .EXACT(1'b0)) u_lk_cam (
        .ent_vpn  (vpn_q),
        .ent_tag  (tag_q),
        .ent_valid(valid_q),
        .ent_glob (glob_q),
        .key_vpn  (lk_va[VA_W-1:PAGE_BITS]),
        .key_tag  (cur_asid),
        .key_glob (1'b0),
        .match    (lk_match),
        .any      (lk_any),
        .first    (lk_idx)
    );

    tlb_cam #(.N(N), .VPN_W(VPN_W), .TAG_W(ASID_W), .EXACT(1'b1)) u_fill_cam (
        .ent_vpn  (vpn_q),
        .ent_tag  (tag_q),
        .ent_valid(valid_q),
        .ent_glob (glob_q),
        .key_vpn  (fill_va[VA_W-1:PAGE_BITS]),
        .key_tag  (cur_asid),
        .key_glob (fill_global),
        .match    (f_match),
        .any      (f_any),
        .first    (f_idx)
    );

    tlb_clock_repl #(.N(N)) u_repl (
        .valid   (valid_q),
        .refb    (ref_q),
        .hand    (hand_q),
        .mode    (pick_mode),
        .victim  (victim),
        .clr     (sweep_clr),
        .hand_nxt(hand_nxt)
    );

    // lookup output: pre-update contents, same cycle
    assign lk_hit = lk_any;
    assign lk_pa  = lk_any ? {pfn_q[lk_idx], lk_va[PAGE_BITS-1:0]} : '0;

    assign op     = inv_op_e'(inv_op);
    assign wr_idx = f_any ? f_idx : victim;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            unique case (op)
                INV_ALL:      kill[i] = inv_en;
                INV_NONGLOB:  kill[i] = inv_en & !glob_q[i];
                INV_ONE_ASID: kill[i] = inv_en & !glob_q[i] & (tag_q[i] == inv_asid);
                default:      kill[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        valid_n = valid_q & ~kill;
        ref_n   = ref_q;
        hand_n  = hand_q;
        if (fill_en && !f_any) begin
            ref_n = ref_n & ~sweep_clr;
            if (pick_mode != PICK_FREE) hand_n = hand_nxt;
        end
        if (lk_any) ref_n[lk_idx] = 1'b1;
        if (fill_en) begin
            valid_n[wr_idx] = 1'b1;
            ref_n[wr_idx]   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            ref_q   <= '0;
            hand_q  <= '0;
            glob_q  <= '0;
            vpn_q   <= '0;
            pfn_q   <= '0;
            tag_q   <= '0;
        end else begin
            valid_q <= valid_n;
            ref_q   <= ref_n;
            hand_q  <= hand_n;
            if (fill_en) begin
                vpn_q[wr_idx]  <= fill_va[VA_W-1:PAGE_BITS];
                pfn_q[wr_idx]  <= fill_pa[PA_W-1:PAGE_BITS];
                tag_q[wr_idx]  <= cur_asid;
                glob_q[wr_idx] <= fill_global;
            end
        end
    end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
    parameter int N    = 4,
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [VA_W-1:0] lk_va,
    input logic [11:0]     cur_asid,
    input logic            lk_hit,
    input logic [PA_W-1:0] lk_pa,
    input logic            fill_en,
    input logic [VA_W-1:0] fill_va,
    input logic            inv_en,
    input logic [1:0]      inv_op,
    input logic [N-1:0]    valid_q
);

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

    p_fill_then_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ((lk_va[VA_W-1:12] != $past(fill_va[VA_W-1:12]))
                     || (cur_asid != $past(cur_asid)) || lk_hit));

    p_fill_occupies_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q != '0));

    p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_op == 2'd0 && !fill_en) |=> !lk_hit);

    p_hit_needs_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q != '0));

endmodule

bind asid_tlb asid_tlb_chk #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_va   (lk_va),
    .cur_asid(cur_asid),
    .lk_hit  (lk_hit),
    .lk_pa   (lk_pa),
    .fill_en (fill_en),
    .fill_va (fill_va),
    .inv_en  (inv_en),
    .inv_op  (inv_op),
    .valid_q (valid_q)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = 32'hFFFF_F000;
    logic [11:0] cur_asid = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        fill_en = 1'b0;
    logic [31:0] fill_va = '0;
    logic [31:0] fill_pa = '0;
    logic        fill_global = 1'b0;
    logic        inv_en = 1'b0;
    logic [1:0]  inv_op = 2'd3;
    logic [11:0] inv_asid = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    asid_tlb #(.N(4), .VA_W(32), .PA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .cur_asid(cur_asid),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .fill_en(fill_en), .fill_va(fill_va),
        .fill_pa(fill_pa), .fill_global(fill_global), .inv_en(inv_en),
        .inv_op(inv_op), .inv_asid(inv_asid)
    );

    // {va, asid, expected hit, expected pa}
    localparam logic [76:0] TAB [7] = '{
        {32'h0001_0ABC, 12'd5, 1'b1, 32'h0020_0ABC},
        {32'h0001_0ABC, 12'd7, 1'b1, 32'h0040_0ABC},
        {32'h0001_0123, 12'd9, 1'b0, 32'h0000_0000},
        {32'h0002_0FFF, 12'd9, 1'b1, 32'h0030_0FFF},
        {32'h0003_0000, 12'd7, 1'b0, 32'h0000_0000},
        {32'h0003_0001, 12'd5, 1'b1, 32'h0050_0001},
        {32'h0004_0000, 12'd5, 1'b0, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual hit=%0b pa=%h expected hit=%0b pa=%h",
                     req, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    // drive a lookup, sample mid-cycle, then let one edge pass
    task automatic look(input logic [31:0] va, input logic [11:0] asid,
                        input logic eh, input logic [31:0] epa, input string req);
        lk_va = va;
        cur_asid = asid;
        #2;
        check(req, {lk_hit, lk_pa}, {eh, epa});
        @(negedge clk);
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa,
                        input logic [11:0] asid, input logic g);
        lk_va = 32'hFFFF_F000;
        cur_asid = asid;
        fill_va = va;
        fill_pa = pa;
        fill_global = g;
        fill_en = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic inval(input logic [1:0] op, input logic [11:0] a);
        lk_va = 32'hFFFF_F000;
        inv_en = 1'b1;
        inv_op = op;
        inv_asid = a;
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset leaves every slot empty
        look(32'h0000_0000, 12'd0, 1'b0, 32'h0, "R12 empty after reset");
        look(32'h0001_0ABC, 12'd5, 1'b0, 32'h0, "R12 empty after reset");
        rst_n = 1'b1;
        @(negedge clk);
        look(32'h0001_0ABC, 12'd5, 1'b0, 32'h0, "R12 miss after release");

        // four fills take slots 0..3 (R5 lowest empty first)
        fill(32'h0001_0000, 32'h0020_0000, 12'd5, 1'b0); // A -> slot0
        fill(32'h0002_0000, 32'h0030_0000, 12'd5, 1'b1); // B global -> slot1
        fill(32'h0001_0000, 32'h0040_0000, 12'd7, 1'b0); // C -> slot2
        fill(32'h0003_0000, 32'h0050_0000, 12'd5, 1'b0); // D -> slot3

        for (int i = 0; i < 7; i++) begin
            look(TAB[i][76:45], TAB[i][44:33], TAB[i][32], TAB[i][31:0],
                 "R1 R2 R3 R4 table");
        end

        // R6 wrap: all referenced, hand 0 -> evict slot0 (A), hand 1
        fill(32'h0005_0000, 32'h0060_0000, 12'd5, 1'b0); // E
        look(32'h0001_0ABC, 12'd5, 1'b0, 32'h0, "R6 R5 wrap evicts slot0");
        look(32'h0005_0010, 12'd5, 1'b1, 32'h0060_0010, "R6 new entry hits");
        look(32'h0001_0ABC, 12'd7, 1'b1, 32'h0040_0ABC, "R4 other tag kept");
        // refs now 1,0,1,0 hand 1 -> F evicts slot1 (B)
        fill(32'h0006_0000, 32'h0070_0000, 12'd5, 1'b0);
        look(32'h0002_0000, 12'd9, 1'b0, 32'h0, "R6 sweep stops at clear bit");
        // refs 1,1,1,0 hand 2 -> G clears slot2, evicts slot3 (D)
        fill(32'h0007_0000, 32'h0080_0000, 12'd5, 1'b0);
        look(32'h0003_0000, 12'd5, 1'b0, 32'h0, "R6 skip one evict next");
        // refs 1,1,0,1 hand 0 -> H clears 0,1 evicts slot2 (C)
        fill(32'h0008_0000, 32'h0090_0000, 12'd5, 1'b0);
        look(32'h0001_0ABC, 12'd7, 1'b0, 32'h0, "R6 cleared bit gives no second chance");
        look(32'h0008_0004, 12'd5, 1'b1, 32'h0090_0004, "R6 refill hits");

        // R7: rewrite E in place (slot0), hand stays 3
        fill(32'h0005_0000, 32'h00A0_0000, 12'd5, 1'b0);
        look(32'h0005_0123, 12'd5, 1'b1, 32'h00A0_0123, "R7 rewrite in place");
        // refs 1,0,1,1 hand 3 -> I clears 3,0 evicts slot1 (F)
        fill(32'h0009_0000, 32'h00C0_0000, 12'd5, 1'b0);
        look(32'h0006_0000, 12'd5, 1'b0, 32'h0, "R7 no duplicate slot");
        look(32'h0005_0001, 12'd5, 1'b1, 32'h00A0_0001, "R7 rewritten entry kept");
        look(32'h0007_0002, 12'd5, 1'b1, 32'h0080_0002, "R7 G kept");

        // R8: code 3 does nothing, code 0 clears all
        inval(2'd3, 12'd5);
        look(32'h0009_0FFF, 12'd5, 1'b1, 32'h00C0_0FFF, "R8 code 3 ignored");
        inval(2'd0, 12'd0);
        look(32'h0009_0FFF, 12'd5, 1'b0, 32'h0, "R8 flush all");
        look(32'h0005_0001, 12'd5, 1'b0, 32'h0, "R8 flush all");

        fill(32'h000A_0000, 32'h00D0_0000, 12'd3, 1'b1); // J global, tag 3
        fill(32'h000B_0000, 32'h00E0_0000, 12'd3, 1'b0); // K
        fill(32'h000B_0000, 32'h00F0_0000, 12'd4, 1'b0); // L
        look(32'h000A_0777, 12'h123, 1'b1, 32'h00D0_0777, "R3 global any tag");
        look(32'h000B_0001, 12'd3, 1'b1, 32'h00E0_0001, "R4 tag 3 frame");
        look(32'h000B_0001, 12'd4, 1'b1, 32'h00F0_0001, "R4 tag 4 frame");

        // R11 / R10: flush tag 3 with a lookup in the same cycle
        inv_en = 1'b1;
        inv_op = 2'd2;
        inv_asid = 12'd3;
        lk_va = 32'h000B_0002;
        cur_asid = 12'd3;
        #2;
        check("R11 same-cycle sees old contents", {lk_hit, lk_pa}, {1'b1, 32'h00E0_0002});
        @(negedge clk);
        inv_en = 1'b0;
        #2;
        check("R10 tag flush removes entry", {lk_hit, lk_pa}, {1'b0, 32'h0});
        @(negedge clk);
        look(32'h000B_0003, 12'd4, 1'b1, 32'h00F0_0003, "R10 other tag kept");
        look(32'h000A_0003, 12'd3, 1'b1, 32'h00D0_0003, "R10 global with same tag kept");

        // R9: non-global flush
        inval(2'd1, 12'd0);
        look(32'h000B_0003, 12'd4, 1'b0, 32'h0, "R9 non-global removed");
        look(32'h000A_0004, 12'd8, 1'b1, 32'h00D0_0004, "R9 global kept");

        // R12: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        look(32'h000A_0004, 12'd8, 1'b0, 32'h0, "R12 reset clears");

        finish_run();
    end

endmodule